// File: doc/BRIEF.md
# Host-Adapter Mailbox Interrupt Controller

This block holds the interrupt status and doorbell registers through which a host processor and an adapter hand command, status and acknowledge blocks to each other in shared memory. The adapter reports its events (command accepted, status posted, a command waiting for the host, adapter check, timer expiry, internal error and invalid access) as single-cycle pulses. Each pulse sets a sticky bit in one of two host status registers. The host clears those bits with an AND operation, and a master enable gates a single level-sensitive host interrupt.

In the other direction the host rings doorbells in an adapter-side register: new command posted, new response posted, and a note that an adapter block or the status block is free again. When the host wants to post while an earlier block is still outstanding, it sets a deferred "tell me when free" bit. The adapter pulses a take strobe when it consumes a doorbell. If the matching deferred bit is set, that consumption raises the completion bit on the host side, so the host is interrupted exactly when the mailbox frees up.

All three registers are accessed through one port. The host picks a register and an operation (write, AND, OR), and the read data always shows the selected register.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `adp_bell` is 0 and `host_irq` is low.
- R2: An `adp_evt` pulse sets a host status bit on the next clock, and that bit stays set until the host clears it. The mapping is: [0] to odd bit 6 (adapter check), [1] to odd bit 5 (command response), [2] to odd bit 3 (adapter command waiting), [3] to odd bit 2 (status posted), [4] to even bit 4 (timer), [5] to even bit 3 (internal error) and [6] to even bit 2 (invalid access).
- R3: Host status event bits are cleared only by a host AND (`host_op`=1). A zero in the write data clears the bit. WRITE (0) and OR (2) leave event bits unchanged. When an event sets a bit in the same cycle as an AND clears it, the bit ends up set.
- R4: Even-register bit 6 (master enable) and bit 0 (alternate adapter) follow every host operation on `host_sel`=0. Unused status bits (even 7,5,1 and odd 7,1,0) always read 0.
- R5: `host_irq` is high exactly when even bit 6 is 1 and at least one event bit (even 4:2 or odd 6:2) is set. With the enable at 0 there is no interrupt.
- R6: Host operations on `host_sel`=2 act on the doorbell register, whose bits 5:0 appear on `adp_bell`: bit 5 is new command, bit 4 is new response, bit 3 is notify on command free, bit 2 is notify on response consumed, bit 1 is adapter block free and bit 0 is status block free. Bits 7:6 read 0.
- R7: The `adp_take` strobes [3], [2], [1] and [0] clear doorbell bits 5, 4, 1 and 0. A take of a bit that is already clear has no effect. A host operation in the same cycle is applied after the take.
- R8: Taking a set command doorbell while bit 3 is set raises odd bit 5 and clears bit 3. Without bit 3 set, or when bit 5 is already clear, odd bit 5 is not raised.
- R9: Taking a set response doorbell raises odd bit 4 (acknowledge free) only if doorbell bit 2 is set or `adp_resp_err` is high, and it clears bit 2. Odd bit 4 has no other source.
- R10: `host_sel`=3 reads 0x00 and its writes change nothing. `host_op`=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register operation strobe |
| host_op | input | 2 | 0 write, 1 AND, 2 OR, 3 none |
| host_sel | input | 2 | 0 host even, 1 host odd, 2 doorbell, 3 none |
| host_wdata | input | 8 | Host operand |
| host_rdata | output | 8 | Selected register contents |
| adp_evt | input | 7 | Adapter event pulses (mapping in R2) |
| adp_take | input | 4 | Adapter doorbell consumption strobes |
| adp_resp_err | input | 1 | Error found in the host response being taken |
| adp_bell | output | 6 | Doorbell register as seen by the adapter |
| host_irq | output | 1 | Host interrupt request |

## Verification
The hardest case to reach is a mailbox completion in which the deferred-notify bit, the doorbell take and a host operation on the same register all land in one cycle. In that cycle the take has to clear the old doorbell, the notify has to fire, and the host's new request has to survive. Directed sequences first set up a pending command or response with and without the notify bit and with the error input, then take it. After that, several thousand random cycles with a fixed seed drive frequent doorbell ORs, takes and AND clears. This makes these collisions common, and each cycle is compared against a bench model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int REG_W  = 8;
  localparam int EVT_W  = 7;
  localparam int TAKE_W = 4;

  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2, OP_NONE = 2'd3} mbx_op_e;
  typedef enum logic [1:0] {SEL_HEVEN = 2'd0, SEL_HODD = 2'd1, SEL_DOOR = 2'd2, SEL_NONE = 2'd3} mbx_sel_e;

  // host even register
  localparam int HE_EN = 6, HE_TMR = 4, HE_ERR = 3, HE_ACC = 2, HE_ALT = 0;
  // host odd register
  localparam int HO_CHK = 6, HO_CMDRSP = 5, HO_ACKFREE = 4, HO_ADPCMD = 3, HO_STSRSP = 2;
  // doorbell register
  localparam int DB_CMD = 5, DB_RSP = 4, DB_CMDWAIT = 3, DB_RSPWAIT = 2, DB_ABFREE = 1, DB_STFREE = 0;

  localparam logic [REG_W-1:0] HE_EVT_MASK = 8'h1C;
  localparam logic [REG_W-1:0] HE_CTL_MASK = 8'h41;
  localparam logic [REG_W-1:0] HO_EVT_MASK = 8'h7C;
  localparam logic [REG_W-1:0] DB_MASK     = 8'h3F;

  function automatic logic [REG_W-1:0] op_apply(input logic [REG_W-1:0] old_v,
                                                input logic [REG_W-1:0] wd,
                                                input logic [1:0] op);
    case (op)
      OP_WRITE: op_apply = wd;
      OP_AND:   op_apply = old_v & wd;
      OP_OR:    op_apply = old_v | wd;
      default:  op_apply = old_v;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] and_keep(input logic hit, input logic [1:0] op,
                                                input logic [REG_W-1:0] wd);
    and_keep = (hit && op == OP_AND) ? wd : '1;
  endfunction

  function automatic logic pending_any(input logic [REG_W-1:0] ev, input logic [REG_W-1:0] od);
    pending_any = |(ev & HE_EVT_MASK) | |(od & HO_EVT_MASK);
  endfunction
endpackage

// File: rtl/mbx_status_reg.sv
module mbx_status_reg
  import mbx_pkg::*;
#(
  parameter logic [REG_W-1:0] EVT_MASK = 8'h00,
  parameter logic [REG_W-1:0] CTL_MASK = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [1:0]       op,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] ctl_nx, evt_nx;

  always_comb begin
    ctl_nx = wr_hit ? (op_apply(q, wdata, op) & CTL_MASK) : (q & CTL_MASK);
    // set has priority over a same-cycle AND clear
    evt_nx = ((q & and_keep(wr_hit, op, wdata)) | set_vec) & EVT_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= ctl_nx | evt_nx;
  end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        op,
  input  logic [REG_W-1:0]  wdata,
  input  logic [TAKE_W-1:0] take,
  input  logic              resp_err,
  output logic [REG_W-1:0]  q,
  output logic              cmd_done,
  output logic              resp_done,
  output logic              cmd_notify,
  output logic              ack_notify
);
  logic [REG_W-1:0] nx;

  assign cmd_done   = take[3] & q[DB_CMD];
  assign resp_done  = take[2] & q[DB_RSP];
  assign cmd_notify = cmd_done & q[DB_CMDWAIT];
  assign ack_notify = resp_done & (q[DB_RSPWAIT] | resp_err);

  always_comb begin
    nx = q;
    if (take[3]) nx[DB_CMD]    = 1'b0;
    if (take[2]) nx[DB_RSP]    = 1'b0;
    if (take[1]) nx[DB_ABFREE] = 1'b0;
    if (take[0]) nx[DB_STFREE] = 1'b0;
    if (cmd_done)  nx[DB_CMDWAIT] = 1'b0;
    if (resp_done) nx[DB_RSPWAIT] = 1'b0;
    if (wr_hit) nx = op_apply(nx, wdata, op);
    nx = nx & DB_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nx;
  end
endmodule

// File: rtl/mbx_irq_merge.sv
module mbx_irq_merge
  import mbx_pkg::*;
(
  input  logic [REG_W-1:0] even_q,
  input  logic [REG_W-1:0] odd_q,
  output logic             irq
);
  assign irq = even_q[HE_EN] & pending_any(even_q, odd_q);
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_op,
  input  logic [1:0]        host_sel,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic [EVT_W-1:0]  adp_evt,
  input  logic [TAKE_W-1:0] adp_take,
  input  logic              adp_resp_err,
  output logic [5:0]        adp_bell,
  output logic              host_irq
);
  logic hit_even, hit_odd, hit_door;
  logic [REG_W-1:0] set_even, set_odd;
  logic [REG_W-1:0] even_q, odd_q, bell_q;
  logic cmd_done, resp_done, cmd_notify, ack_notify;

  assign hit_even = host_we && host_sel == SEL_HEVEN;
  assign hit_odd  = host_we && host_sel == SEL_HODD;
  assign hit_door = host_we && host_sel == SEL_DOOR;

  always_comb begin
    set_even = '0;
    set_even[HE_TMR] = adp_evt[4];
    set_even[HE_ERR] = adp_evt[5];
    set_even[HE_ACC] = adp_evt[6];
    set_odd = '0;
    set_odd[HO_CHK]     = adp_evt[0];
    set_odd[HO_CMDRSP]  = adp_evt[1] | cmd_notify;
    set_odd[HO_ACKFREE] = ack_notify;
    set_odd[HO_ADPCMD]  = adp_evt[2];
    set_odd[HO_STSRSP]  = adp_evt[3];
  end

  mbx_status_reg #(.EVT_MASK(HE_EVT_MASK), .CTL_MASK(HE_CTL_MASK)) u_even (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_even), .op(host_op), .wdata(host_wdata),
    .set_vec(set_even), .q(even_q));

  mbx_status_reg #(.EVT_MASK(HO_EVT_MASK), .CTL_MASK(8'h00)) u_odd (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_odd), .op(host_op), .wdata(host_wdata),
    .set_vec(set_odd), .q(odd_q));

  mbx_doorbell u_door (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_door), .op(host_op), .wdata(host_wdata),
    .take(adp_take), .resp_err(adp_resp_err), .q(bell_q),
    .cmd_done(cmd_done), .resp_done(resp_done), .cmd_notify(cmd_notify), .ack_notify(ack_notify));

  mbx_irq_merge u_irq (.even_q(even_q), .odd_q(odd_q), .irq(host_irq));

  assign adp_bell = bell_q[5:0];

  always_comb begin
    case (host_sel)
      SEL_HEVEN: host_rdata = even_q;
      SEL_HODD:  host_rdata = odd_q;
      SEL_DOOR:  host_rdata = bell_q;
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_we,
  input logic [1:0] host_op,
  input logic [1:0] host_sel,
  input logic       evt_chk,
  input logic       evt_acc,
  input logic [3:2] take_hi,
  input logic       resp_err,
  input logic [7:0] even_q,
  input logic [7:0] odd_q,
  input logic [7:0] bell_q,
  input logic       host_irq,
  input logic       cmd_done,
  input logic       resp_done
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_chk |=> odd_q[6]);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_q[5] && !(host_we && host_sel == 2'd1 && host_op == 2'd1)) |=> odd_q[5]);

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_acc && even_q[6] && !(host_we && host_sel == 2'd0)) |=> host_irq);

  assert_take_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_hi[3] && !(host_we && host_sel == 2'd2)) |=> !bell_q[5]);

  assert_cmd_notify_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && bell_q[3]) |=> odd_q[5]);

  assert_ack_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && !bell_q[2] && !resp_err && !odd_q[4]) |=> !odd_q[4]);

  assert_ack_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_hi[2] && bell_q[4] && resp_err) |=> odd_q[4]);
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_op(host_op), .host_sel(host_sel),
  .evt_chk(adp_evt[0]), .evt_acc(adp_evt[6]), .take_hi(adp_take[3:2]), .resp_err(adp_resp_err),
  .even_q(even_q), .odd_q(odd_q), .bell_q(bell_q), .host_irq(host_irq),
  .cmd_done(cmd_done), .resp_done(resp_done));

// File: tb/tb_mbx_irq_ctrl.sv
module tb_mbx_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_op = 2'd3, host_sel = 2'd3;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [6:0] adp_evt = '0;
  logic [3:0] adp_take = '0;
  logic adp_resp_err = 1'b0;
  logic [5:0] adp_bell;
  logic host_irq;

  int total = 0, bad = 0;
  logic [7:0] m_even = '0, m_odd = '0, m_bell = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq_ctrl dut (.*);

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_reg(input logic [1:0] s);
    if (s == 2'd0) return m_even;
    if (s == 2'd1) return m_odd;
    if (s == 2'd2) return m_bell;
    return 8'h00;
  endfunction

  function automatic logic m_irq();
    return m_even[6] && ((m_even & 8'h1C) != 0 || (m_odd & 8'h7C) != 0);
  endfunction

  // bench model: one clock of the controller, bit by bit
  task automatic model(input logic we, input logic [1:0] op, input logic [1:0] sel,
                       input logic [7:0] wd, input logic [6:0] ev, input logic [3:0] tk,
                       input logic er);
    logic [7:0] ne, no, nb;
    logic cfin, rfin;
    ne = m_even; no = m_odd; nb = m_bell;
    cfin = tk[3] && m_bell[5];
    rfin = tk[2] && m_bell[4];
    if (tk[3]) nb[5] = 0;
    if (tk[2]) nb[4] = 0;
    if (tk[1]) nb[1] = 0;
    if (tk[0]) nb[0] = 0;
    if (cfin) nb[3] = 0;
    if (rfin) nb[2] = 0;
    if (we && op != 2'd3) begin
      if (sel == 2'd0) begin
        for (int b = 0; b < 8; b++) begin
          if (b == 6 || b == 0) begin
            if (op == 2'd0) ne[b] = wd[b];
            else if (op == 2'd1) ne[b] = ne[b] & wd[b];
            else ne[b] = ne[b] | wd[b];
          end else if (op == 2'd1) ne[b] = ne[b] & wd[b];
        end
      end else if (sel == 2'd1) begin
        if (op == 2'd1) no = no & wd;
      end else if (sel == 2'd2) begin
        if (op == 2'd0) nb = wd;
        else if (op == 2'd1) nb = nb & wd;
        else nb = nb | wd;
        nb[7:6] = 2'b00;
      end
    end
    if (ev[0]) no[6] = 1;
    if (ev[1]) no[5] = 1;
    if (ev[2]) no[3] = 1;
    if (ev[3]) no[2] = 1;
    if (ev[4]) ne[4] = 1;
    if (ev[5]) ne[3] = 1;
    if (ev[6]) ne[2] = 1;
    if (cfin && m_bell[3]) no[5] = 1;
    if (rfin && (m_bell[2] || er)) no[4] = 1;
    m_even = ne & 8'h5D; m_odd = no & 8'h7C; m_bell = nb;
  endtask

  task automatic step(input logic we, input logic [1:0] op, input logic [1:0] sel,
                      input logic [7:0] wd, input logic [6:0] ev, input logic [3:0] tk,
                      input logic er);
    host_we = we; host_op = op; host_sel = sel; host_wdata = wd;
    adp_evt = ev; adp_take = tk; adp_resp_err = er;
    model(we, op, sel, wd, ev, tk, er);
    @(posedge clk);
    @(negedge clk);
    host_we = 0; adp_evt = '0; adp_take = '0; adp_resp_err = 0;
  endtask

  task automatic rd(input string tag, input logic [1:0] sel, input logic [7:0] exp);
    host_we = 0; host_sel = sel; #1;
    chk(tag, host_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] op, input logic [7:0] wd);
    step(1, op, sel, wd, '0, '0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1 even", 2'd0, 8'h00); rd("R1 odd", 2'd1, 8'h00); rd("R1 door", 2'd2, 8'h00);
    chk("R1 bell", {2'b0, adp_bell}, 8'h00); chk("R1 irq", {7'b0, host_irq}, 8'h00);

    // R4 control bits
    wr(2'd0, 2'd0, 8'hFF); rd("R4 write all", 2'd0, 8'h41);
    wr(2'd0, 2'd1, 8'h40); rd("R4 and", 2'd0, 8'h40);
    wr(2'd0, 2'd2, 8'h01); rd("R4 or", 2'd0, 8'h41);

    // R2 events, R5 interrupt
    step(0, 2'd3, 2'd3, 8'h00, 7'h7F, '0, 0);
    rd("R2 even", 2'd0, 8'h5D); rd("R2 odd", 2'd1, 8'h6C);
    chk("R5 irq on", {7'b0, host_irq}, 8'h01);

    // R3 write/or leave events; R5 enable gating
    wr(2'd0, 2'd0, 8'h00); rd("R3 write keeps events", 2'd0, 8'h1C);
    chk("R5 irq off when disabled", {7'b0, host_irq}, 8'h00);
    wr(2'd0, 2'd2, 8'h40); chk("R5 irq re-enabled", {7'b0, host_irq}, 8'h01);
    wr(2'd1, 2'd2, 8'h00); rd("R3 or keeps odd", 2'd1, 8'h6C);
    wr(2'd1, 2'd1, 8'h00); rd("R3 and clears odd", 2'd1, 8'h00);
    wr(2'd0, 2'd1, 8'hE3); rd("R3 and clears even", 2'd0, 8'h40);
    chk("R5 irq clear", {7'b0, host_irq}, 8'h00);
    step(1, 2'd1, 2'd1, 8'h00, 7'h01, '0, 0); rd("R3 set wins", 2'd1, 8'h40);
    wr(2'd1, 2'd1, 8'h00);

    // R6 doorbells
    wr(2'd2, 2'd2, 8'h20); chk("R6 bell", {2'b0, adp_bell}, 8'h20);
    wr(2'd2, 2'd0, 8'hFF); rd("R6 upper zero", 2'd2, 8'h3F);
    // R7 takes
    step(0, 2'd3, 2'd3, 8'h00, '0, 4'hF, 0); rd("R7 take all", 2'd2, 8'h00);
    rd("R8 notify fired", 2'd1, 8'h30);
    wr(2'd1, 2'd1, 8'h00);
    wr(2'd2, 2'd0, 8'h20);
    step(1, 2'd2, 2'd2, 8'h20, '0, 4'h8, 0); rd("R7 host after take", 2'd2, 8'h20);
    // R8 without wait bit
    step(0, 2'd3, 2'd3, 8'h00, '0, 4'h8, 0); rd("R8 no wait no irq", 2'd1, 8'h00);
    wr(2'd2, 2'd0, 8'h08);
    step(0, 2'd3, 2'd3, 8'h00, '0, 4'h8, 0);
    rd("R7 take of clear bit", 2'd2, 8'h08); rd("R8 idle take", 2'd1, 8'h00);
    wr(2'd2, 2'd0, 8'h28);
    step(0, 2'd3, 2'd3, 8'h00, '0, 4'h8, 0);
    rd("R8 deferred fired", 2'd1, 8'h20); rd("R8 wait cleared", 2'd2, 8'h00);
    chk("R5 irq from completion", {7'b0, host_irq}, 8'h01);
    wr(2'd1, 2'd1, 8'h00);

    // R9 acknowledge free
    wr(2'd2, 2'd0, 8'h10);
    step(0, 2'd3, 2'd3, 8'h00, '0, 4'h4, 0); rd("R9 no request", 2'd1, 8'h00);
    wr(2'd2, 2'd0, 8'h14);
    step(0, 2'd3, 2'd3, 8'h00, '0, 4'h4, 0);
    rd("R9 requested", 2'd1, 8'h10); rd("R9 wait cleared", 2'd2, 8'h00);
    wr(2'd1, 2'd1, 8'h00);
    wr(2'd2, 2'd0, 8'h10);
    step(0, 2'd3, 2'd3, 8'h00, '0, 4'h4, 1); rd("R9 error", 2'd1, 8'h10);
    wr(2'd1, 2'd1, 8'h00);

    // R10 ignored select and op
    wr(2'd2, 2'd0, 8'h15);
    wr(2'd3, 2'd0, 8'hFF); rd("R10 sel3 read", 2'd3, 8'h00);
    rd("R10 even kept", 2'd0, 8'h40); rd("R10 door kept", 2'd2, 8'h15);
    wr(2'd2, 2'd3, 8'h00); rd("R10 op3 door", 2'd2, 8'h15);
    wr(2'd0, 2'd3, 8'h00); rd("R10 op3 even", 2'd0, 8'h40);

    // random phase (R2, R5, R6 against the model)
    void'($urandom(32'h5A17));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s, o;
      logic [6:0] e;
      logic [3:0] t;
      s = 2'($urandom_range(0, 3));
      o = 2'($urandom_range(0, 3));
      e = ($urandom_range(0, 3) == 0) ? 7'(1 << $urandom_range(0, 6)) : 7'h00;
      t = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
      step($urandom_range(0, 1) == 1, o, s, 8'($urandom), e, t, $urandom_range(0, 3) == 0);
      chk("R6 random bell", {2'b0, adp_bell}, m_bell);
      chk("R5 random irq", {7'b0, host_irq}, {7'b0, m_irq()});
      chk("R2 random rdata", host_rdata, m_reg(s));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule